// File: doc/BRIEF.md
# ModR/M Effective Address Generator

This block takes the addressing part of one instruction (an optional REX prefix byte, the ModR/M byte, an optional SIB byte and up to four raw displacement bytes) and works out the memory operand's effective address. It also reports the reg-field operand number, the base and index register numbers it used, the operand size, whether the address is relative to the next instruction, and how many addressing bytes the form uses. Base and index register values come from an outside register file. The block drives the read selects for that file from its input bytes with no register in between, and the file answers in the same cycle.

Requests enter on a valid/ready handshake. Results leave on a second valid/ready handshake one clock after they are accepted. `in_ready` is high when the output stage is empty or is being drained in that same cycle. A result that the consumer has not taken keeps all of its fields unchanged until `out_ready` is seen high. Opcode decoding, segmentation and the memory access itself belong to other blocks.

Top module: `modrm_agen`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. A request accepted at a clock edge sets `out_valid` at that edge. While `out_valid && !out_ready`, every output field keeps its value.
- R2: `reg_idx` is {REX.R, ModR/M[5:3]} and `op64` is REX.W. The REX bits are W=bit3, R=bit2, X=bit1, B=bit0.
- R3: mod=11 is a register operand. `ea_valid` is 0, `has_base`/`has_index` are 0, `base_idx` is {REX.B, r/m}, and no displacement byte is counted.
- R4: In 64-bit mode, mod=00 with r/m=101 gives `ea` = `next_ip` + sign-extended 32-bit displacement, with `rip_rel`=1 and no base or index. REX.B=1 does not change this.
- R5: Outside 64-bit mode, mod=00 with r/m=101 gives `ea` = zero-extended 32-bit displacement, with `rip_rel`=0.
- R6: mod=01 adds a sign-extended 8-bit displacement (disp[7:0]) and mod=10 adds a 32-bit displacement to the base. Register 13 with mod=01 and displacement 0 addresses exactly that register's value.
- R7: r/m=100 with mod≠11 reads a SIB byte (scale=[7:6], index=[5:3], base=[2:0]). The index is {REX.X, index} shifted left by scale. Index field 100 with REX.X=0 means no index, so register 4 is never an index. With REX.X=1 the same field selects register 12.
- R8: A SIB base field of 101 with mod=00 means no base and a 32-bit displacement. This holds whatever REX.B is, and the form is absolute even in 64-bit mode.
- R9: In 64-bit mode with `addr_ovr`=1, `ea` is the low 32 bits of the sum, zero-extended. Relative-to-next-instruction addressing still applies. Outside 64-bit mode `ea` is always the 32-bit, zero-extended result.
- R10: `byte_cnt` = (REX used) + 1 + (SIB present) + displacement bytes. For bytes 4C 8B 2D plus four displacement bytes this is 6, or 7 when the opcode byte is added.
- R11: The REX byte is used only when `long_mode`=1, `rex_present`=1 and its high nibble is 0100. Otherwise W, R, X and B are 0 and the byte is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted when high with in_valid |
| long_mode | input | 1 | 64-bit mode |
| addr_ovr | input | 1 | Address-size override prefix seen |
| rex_present | input | 1 | rex_byte holds a prefix |
| rex_byte | input | 8 | Prefix byte |
| modrm | input | 8 | ModR/M byte |
| sib | input | 8 | SIB byte (used only when present) |
| disp | input | 32 | Displacement bytes, first byte in [7:0] |
| next_ip | input | 64 | Address of the following instruction |
| rf_base_sel | output | 4 | Register-file read select for the base |
| rf_index_sel | output | 4 | Register-file read select for the index |
| base_val | input | 64 | Value of register rf_base_sel |
| index_val | input | 64 | Value of register rf_index_sel |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| reg_idx | output | 4 | Reg-field operand number |
| base_idx | output | 4 | Base register number |
| index_idx | output | 4 | Index register number |
| has_base | output | 1 | A base register was added |
| has_index | output | 1 | An index register was added |
| op64 | output | 1 | 64-bit operand size |
| rip_rel | output | 1 | Address relative to next instruction |
| byte_cnt | output | 3 | Addressing bytes consumed |
| ea_valid | output | 1 | ea holds a memory address |
| ea | output | 64 | Effective address |

## Verification
The directed cases cover the corners where decoders usually go wrong. REX.B=1 with mod=00, r/m=101 must stay relative to the next instruction, and a design that decodes all four bits would read register 13. SIB base 101 with mod=00 must be absolute, and a design that wrongly applies the relative form there adds `next_ip`. Index field 100 must be dropped only when REX.X=0. A design that ignores REX.X loses register 12, and one that does not drop the field adds register 4. The address-size override must truncate a relative address to 32 bits, so a design that skips this shows high bits. A stalled result must not change while a new request waits. Random mixes of all bytes in both modes are compared against a bench model.

// File: rtl/agen_pkg.sv
package agen_pkg;

  typedef enum logic [1:0] {
    DISP_NONE = 2'd0,
    DISP_8    = 2'd1,
    DISP_32   = 2'd2
  } disp_kind_e;

  typedef struct packed {
    logic       w;
    logic       r;
    logic       x;
    logic       b;
  } rex_bits_t;

  typedef struct packed {
    logic [3:0] reg_idx;
    logic [3:0] base_idx;
    logic [3:0] index_idx;
    logic       has_base;
    logic       has_index;
    logic       is_mem;
    logic       rip_rel;
    logic       op64;
    logic [1:0] scale;
    disp_kind_e disp_kind;
    logic [2:0] byte_cnt;
  } dec_t;

endpackage

// File: rtl/agen_decode.sv
module agen_decode
  import agen_pkg::*;
(
  input  logic       long_mode,
  input  logic       rex_present,
  input  logic [7:0] rex_byte,
  input  logic [7:0] modrm,
  input  logic [7:0] sib,
  output dec_t       dec
);
  localparam logic [3:0] REX_NIBBLE = 4'h4;
  localparam logic [2:0] FIELD_SIB  = 3'b100;
  localparam logic [2:0] FIELD_D32  = 3'b101;

  logic       rex_used;
  rex_bits_t  rx;
  logic [1:0] md;
  logic [2:0] rm;
  logic       sib_here;
  logic [2:0] base_field;
  logic       no_base;

  always_comb begin
    rex_used   = long_mode && rex_present && (rex_byte[7:4] == REX_NIBBLE);
    rx         = rex_used ? rex_bits_t'(rex_byte[3:0]) : '0;
    md         = modrm[7:6];
    rm         = modrm[2:0];
    sib_here   = (md != 2'b11) && (rm == FIELD_SIB);
    base_field = sib_here ? sib[2:0] : rm;
    no_base    = (md == 2'b00) && (base_field == FIELD_D32);

    dec           = '0;
    dec.reg_idx   = {rx.r, modrm[5:3]};
    dec.op64      = rx.w;
    dec.is_mem    = (md != 2'b11);
    dec.base_idx  = {rx.b, base_field};
    dec.index_idx = {rx.x, sib[5:3]};
    dec.scale     = sib_here ? sib[7:6] : 2'b00;
    dec.has_index = sib_here && !((sib[5:3] == FIELD_SIB) && !rx.x);
    dec.has_base  = dec.is_mem && !no_base;
    dec.rip_rel   = long_mode && (md == 2'b00) && !sib_here && (rm == FIELD_D32);

    unique case (md)
      2'b01:   dec.disp_kind = DISP_8;
      2'b10:   dec.disp_kind = DISP_32;
      2'b00:   dec.disp_kind = no_base ? DISP_32 : DISP_NONE;
      default: dec.disp_kind = DISP_NONE;
    endcase

    dec.byte_cnt = {2'b00, rex_used} + 3'd1 + {2'b00, sib_here}
                 + ((dec.disp_kind == DISP_8)  ? 3'd1 :
                    (dec.disp_kind == DISP_32) ? 3'd4 : 3'd0);
  end
endmodule

// File: rtl/agen_disp.sv
module agen_disp
  import agen_pkg::*;
#(
  parameter int AW = 64
) (
  input  disp_kind_e      kind,
  input  logic [31:0]     raw,
  output logic [AW-1:0]   ext
);
  localparam int EXT8  = AW - 8;
  localparam int EXT32 = AW - 32;

  always_comb begin
    unique case (kind)
      DISP_8:  ext = {{EXT8{raw[7]}}, raw[7:0]};
      DISP_32: ext = {{EXT32{raw[31]}}, raw};
      default: ext = '0;
    endcase
  end
endmodule

// File: rtl/agen_sum.sv
module agen_sum #(
  parameter int AW = 64
) (
  input  logic          has_base,
  input  logic          has_index,
  input  logic          rip_rel,
  input  logic [1:0]    scale,
  input  logic          narrow,
  input  logic [AW-1:0] disp_ext,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] index_val,
  input  logic [AW-1:0] next_ip,
  output logic [AW-1:0] ea
);
  localparam int NW = 32;
  localparam int HW = AW - NW;

  logic [AW-1:0] base_term;
  logic [AW-1:0] index_term;
  logic [AW-1:0] total;

  always_comb begin
    if (rip_rel)       base_term = next_ip;
    else if (has_base) base_term = base_val;
    else               base_term = '0;
    index_term = has_index ? (index_val << scale) : '0;
    total      = disp_ext + base_term + index_term;
    ea         = narrow ? {{HW{1'b0}}, total[NW-1:0]} : total;
  end
endmodule

// File: rtl/modrm_agen.sv
module modrm_agen
  import agen_pkg::*;
#(
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          long_mode,
  input  logic          addr_ovr,
  input  logic          rex_present,
  input  logic [7:0]    rex_byte,
  input  logic [7:0]    modrm,
  input  logic [7:0]    sib,
  input  logic [31:0]   disp,
  input  logic [AW-1:0] next_ip,
  output logic [3:0]    rf_base_sel,
  output logic [3:0]    rf_index_sel,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] index_val,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [3:0]    reg_idx,
  output logic [3:0]    base_idx,
  output logic [3:0]    index_idx,
  output logic          has_base,
  output logic          has_index,
  output logic          op64,
  output logic          rip_rel,
  output logic [2:0]    byte_cnt,
  output logic          ea_valid,
  output logic [AW-1:0] ea
);
  dec_t          dec;
  logic [AW-1:0] disp_ext;
  logic [AW-1:0] ea_next;
  logic          narrow;
  logic          take;

  agen_decode u_decode (
    .long_mode   (long_mode),
    .rex_present (rex_present),
    .rex_byte    (rex_byte),
    .modrm       (modrm),
    .sib         (sib),
    .dec         (dec)
  );

  agen_disp #(.AW(AW)) u_disp (
    .kind (dec.disp_kind),
    .raw  (disp),
    .ext  (disp_ext)
  );

  assign narrow = !long_mode || addr_ovr;

  agen_sum #(.AW(AW)) u_sum (
    .has_base  (dec.has_base),
    .has_index (dec.has_index),
    .rip_rel   (dec.rip_rel),
    .scale     (dec.scale),
    .narrow    (narrow),
    .disp_ext  (disp_ext),
    .base_val  (base_val),
    .index_val (index_val),
    .next_ip   (next_ip),
    .ea        (ea_next)
  );

  assign rf_base_sel  = dec.base_idx;
  assign rf_index_sel = dec.index_idx;
  assign in_ready     = !out_valid || out_ready;
  assign take         = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_idx   <= '0;
      base_idx  <= '0;
      index_idx <= '0;
      has_base  <= 1'b0;
      has_index <= 1'b0;
      op64      <= 1'b0;
      rip_rel   <= 1'b0;
      byte_cnt  <= '0;
      ea_valid  <= 1'b0;
      ea        <= '0;
    end else if (take) begin
      reg_idx   <= dec.reg_idx;
      base_idx  <= dec.base_idx;
      index_idx <= dec.index_idx;
      has_base  <= dec.has_base;
      has_index <= dec.has_index;
      op64      <= dec.op64;
      rip_rel   <= dec.rip_rel;
      byte_cnt  <= dec.byte_cnt;
      ea_valid  <= dec.is_mem;
      ea        <= dec.is_mem ? ea_next : '0;
    end
  end
endmodule

// File: rtl/modrm_agen_chk.sv
module modrm_agen_chk #(
  parameter int AW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          long_mode,
  input logic          addr_ovr,
  input logic [7:0]    modrm,
  input logic          out_valid,
  input logic          out_ready,
  input logic [3:0]    index_idx,
  input logic          has_base,
  input logic          has_index,
  input logic          rip_rel,
  input logic [2:0]    byte_cnt,
  input logic          ea_valid,
  input logic [AW-1:0] ea
);
  logic narrow_q;

  always_ff @(posedge clk) begin
    if (!rst_n) narrow_q <= 1'b0;
    else if (in_valid && in_ready) narrow_q <= !long_mode || addr_ovr;
  end

  // R1: accepted request appears at the next edge
  a_r1_accept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R1: stalled result is held
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(ea) && $stable(byte_cnt));

  // R3: register form produces no address
  a_r3_reg_form: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (modrm[7:6] == 2'b11) |=> !ea_valid && !has_base && !has_index);

  // R4: relative form uses neither base nor index
  a_r4_rel_shape: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && rip_rel |-> ea_valid && !has_base && !has_index);

  // R7: register 4 is never an index
  a_r7_no_sp_index: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && has_index |-> index_idx != 4'd4);

  // R9: narrowed results have clear upper bits
  a_r9_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && ea_valid && narrow_q |-> ea[AW-1:32] == '0);

  // R10: byte count range
  a_r10_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> byte_cnt >= 3'd1);
endmodule

bind modrm_agen modrm_agen_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .long_mode (long_mode),
  .addr_ovr  (addr_ovr),
  .modrm     (modrm),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .index_idx (index_idx),
  .has_base  (has_base),
  .has_index (has_index),
  .rip_rel   (rip_rel),
  .byte_cnt  (byte_cnt),
  .ea_valid  (ea_valid),
  .ea        (ea)
);

// File: tb/modrm_agen_test.sv
module modrm_agen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        long_mode = 1'b1;
  logic        addr_ovr = 1'b0;
  logic        rex_present = 1'b0;
  logic [7:0]  rex_byte = 8'h00;
  logic [7:0]  modrm = 8'h00;
  logic [7:0]  sib = 8'h00;
  logic [31:0] disp = 32'h0;
  logic [63:0] next_ip = 64'h0;
  logic [3:0]  rf_base_sel, rf_index_sel;
  logic [63:0] base_val, index_val;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [3:0]  reg_idx, base_idx, index_idx;
  logic        has_base, has_index, op64, rip_rel, ea_valid;
  logic [2:0]  byte_cnt;
  logic [63:0] ea;

  logic [63:0] regs [16];
  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [3:0]  reg_idx;
    logic [3:0]  base_idx;
    logic [3:0]  index_idx;
    logic        has_index;
    logic        op64;
    logic        rip;
    logic        mem;
    logic [2:0]  cnt;
    logic [63:0] ea;
  } exp_t;

  always #4 clk = ~clk;

  assign base_val  = regs[rf_base_sel];
  assign index_val = regs[rf_index_sel];

  modrm_agen uut (.*);

  function automatic exp_t model(input logic lm, input logic ovr, input logic rp,
      input logic [7:0] rx, input logic [7:0] mr, input logic [7:0] sb,
      input logic [31:0] d, input logic [63:0] nip);
    exp_t e;
    logic act, w, r, x, b, sib_here, nobase;
    logic [2:0] bsel;
    int dsz;
    logic [63:0] dv, sum;
    act = lm && rp && (rx[7:4] == 4'b0100);
    w = act & rx[3]; r = act & rx[2]; x = act & rx[1]; b = act & rx[0];
    sib_here = (mr[7:6] != 2'b11) && (mr[2:0] == 3'd4);
    bsel = sib_here ? sb[2:0] : mr[2:0];
    nobase = (mr[7:6] == 2'b00) && (bsel == 3'd5);
    if (mr[7:6] == 2'b01) dsz = 1;
    else if (mr[7:6] == 2'b10 || nobase) dsz = 4;
    else dsz = 0;
    if (dsz == 1) dv = 64'(signed'(d[7:0]));
    else if (dsz == 4) dv = 64'(signed'(d));
    else dv = 64'h0;
    e.rip = lm && (mr[7:6] == 2'b00) && (mr[2:0] == 3'd5);
    e.has_index = sib_here && ({x, sb[5:3]} != 4'd4);
    e.mem = (mr[7:6] != 2'b11);
    e.reg_idx = {r, mr[5:3]};
    e.base_idx = {b, bsel};
    e.index_idx = {x, sb[5:3]};
    e.op64 = w;
    sum = dv;
    if (e.rip) sum = sum + nip;
    else if (!nobase) sum = sum + regs[{b, bsel}];
    if (e.has_index) sum = sum + (regs[{x, sb[5:3]}] << sb[7:6]);
    if (!lm || ovr) sum = {32'h0, sum[31:0]};
    e.ea = e.mem ? sum : 64'h0;
    e.cnt = 3'(int'(act) + 1 + int'(sib_here) + dsz);
    return e;
  endfunction

  task automatic chk(input logic ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic compare(input exp_t e, input string tag);
    chk(out_valid === 1'b1, {tag, " R1 out_valid"}, 64'(out_valid), 64'h1);
    chk(reg_idx === e.reg_idx, {tag, " R2 reg_idx"}, 64'(reg_idx), 64'(e.reg_idx));
    chk(op64 === e.op64, {tag, " R2 op64"}, 64'(op64), 64'(e.op64));
    chk(ea_valid === e.mem, {tag, " R3 ea_valid"}, 64'(ea_valid), 64'(e.mem));
    chk(base_idx === e.base_idx, {tag, " R3 base_idx"}, 64'(base_idx), 64'(e.base_idx));
    chk(rip_rel === e.rip, {tag, " R4 rip_rel"}, 64'(rip_rel), 64'(e.rip));
    chk(has_index === e.has_index, {tag, " R7 has_index"}, 64'(has_index), 64'(e.has_index));
    if (e.has_index)
      chk(index_idx === e.index_idx, {tag, " R7 index_idx"}, 64'(index_idx), 64'(e.index_idx));
    chk(byte_cnt === e.cnt, {tag, " R10 byte_cnt"}, 64'(byte_cnt), 64'(e.cnt));
    if (e.mem) chk(ea === e.ea, {tag, " ea"}, ea, e.ea);
  endtask

  task automatic drive(input logic lm, input logic ovr, input logic rp, input logic [7:0] rx,
      input logic [7:0] mr, input logic [7:0] sb, input logic [31:0] d, input logic [63:0] nip);
    long_mode = lm; addr_ovr = ovr; rex_present = rp; rex_byte = rx;
    modrm = mr; sib = sb; disp = d; next_ip = nip;
  endtask

  task automatic run(input logic lm, input logic ovr, input logic rp, input logic [7:0] rx,
      input logic [7:0] mr, input logic [7:0] sb, input logic [31:0] d, input logic [63:0] nip,
      input string tag);
    exp_t e;
    @(negedge clk);
    drive(lm, ovr, rp, rx, mr, sb, d, nip);
    in_valid = 1'b1;
    e = model(lm, ovr, rp, rx, mr, sb, d, nip);
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    compare(e, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    exp_t ea_a, ea_b;
    logic [63:0] held;
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) regs[i] = {$urandom, $urandom};
    regs[13] = 64'h0000_7FFF_1234_5670;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid === 1'b0, "R1 reset out_valid", 64'(out_valid), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready === 1'b1, "R1 idle in_ready", 64'(in_ready), 64'h1);

    // R10 R4: 4C 8B 2D disp32 -> reg 13, 64-bit, relative, 6 bytes (+opcode = 7)
    run(1, 0, 1, 8'h4C, 8'h2D, 8'h00, 32'hFFEA_D9ED, 64'hFFFF_F800_0010_0000, "R10 example");
    chk(32'(byte_cnt) + 1 == 7, "R10 total with opcode", 64'(byte_cnt) + 1, 64'd7);
    // R4: REX.B=1 does not select register 13
    run(1, 0, 1, 8'h41, 8'h05, 8'h00, 32'h0000_0100, 64'h0000_1234_0000_0000, "R4 rexb");
    // R5: legacy absolute
    run(0, 0, 0, 8'h00, 8'h05, 8'h00, 32'h8000_0040, 64'h0000_0000_0040_0000, "R5 legacy");
    // R6: register 13 with zero disp8
    run(1, 0, 1, 8'h41, 8'h45, 8'h00, 32'h0, 64'h0, "R6 r13 disp0");
    // R6: negative disp8 and disp32
    run(1, 0, 1, 8'h48, 8'h43, 8'h00, 32'h0000_00F0, 64'h0, "R6 neg8");
    run(1, 0, 0, 8'h00, 8'h81, 8'h00, 32'hFFFF_0000, 64'h0, "R6 neg32");
    // R7: index field 100 without / with REX.X
    run(1, 0, 0, 8'h00, 8'h04, 8'hE3, 32'h0, 64'h0, "R7 no index");
    run(1, 0, 1, 8'h42, 8'h04, 8'hA3, 32'h0, 64'h0, "R7 r12 index");
    // R8: SIB base 101 mod00 absolute in 64-bit mode, also with REX.B
    run(1, 0, 1, 8'h41, 8'h04, 8'h4D, 32'h0000_2000, 64'hDEAD_0000_0000_0000, "R8 sib nobase");
    // R9: override truncates a relative address
    run(1, 1, 0, 8'h00, 8'h05, 8'h00, 32'h7000_0000, 64'h0000_0001_9000_0000, "R9 ovr rel");
    // R3: register form
    run(1, 0, 1, 8'h49, 8'hC8, 8'h00, 32'h0, 64'h0, "R3 regform");
    // R11: REX ignored outside 64-bit mode and with a bad nibble
    run(0, 0, 1, 8'h4F, 8'h3C, 8'h24, 32'h0, 64'h0, "R11 legacy rex");
    run(1, 0, 1, 8'h5F, 8'h3C, 8'h24, 32'h0, 64'h0, "R11 bad nibble");

    // R1: back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    drive(1, 0, 0, 8'h00, 8'h80, 8'h00, 32'h0000_1111, 64'h0);
    ea_a = model(1, 0, 0, 8'h00, 8'h80, 8'h00, 32'h0000_1111, 64'h0);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(in_ready === 1'b0, "R1 stall in_ready", 64'(in_ready), 64'h0);
    drive(1, 0, 1, 8'h48, 8'h44, 8'h91, 32'h0000_0008, 64'h0);
    ea_b = model(1, 0, 1, 8'h48, 8'h44, 8'h91, 32'h0000_0008, 64'h0);
    held = ea;
    @(posedge clk);
    @(negedge clk);
    chk(ea === held && ea === ea_a.ea, "R1 held ea", ea, ea_a.ea);
    out_ready = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    compare(ea_b, "R1 after stall");

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [7:0] rx;
      rx = ($urandom % 4 == 0) ? 8'($urandom) : {4'h4, 4'($urandom)};
      run(1'($urandom), 1'($urandom), 1'($urandom), rx, 8'($urandom), 8'($urandom),
          $urandom, {$urandom, $urandom}, "rand");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule